// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Drift Trim and Pin Output Select

This block divides a slow timebase, delivered as a one-cycle source enable at roughly 32.768 kHz, down to a one-second tick and a one-minute tick. Crystal drift is corrected digitally. A signed calibration value moves the length of one second per minute by four source counts per step. A positive value makes that second shorter and a negative value makes it longer. All other seconds keep the nominal length.

A single output pin can carry one of three signals: the external alarm pulse, a 50% duty seconds square wave, or the raw source enable. A 2-bit select code chooses the signal and an output enable gates it. The calibration value, the select code and the enable are held in configuration registers that load on one write strobe. All three are zero after reset. The calibration value is copied into an active copy at each minute boundary, so a write made part way through a minute does not disturb that minute.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset the calibration value, select code and output enable are zero. The pin is low, no tick is pulsed, and the first second after reset is nominal.
- R2: With an active calibration of 0x00, every second lasts SEC_COUNTS source enables (default 32768).
- R3: A positive active calibration C (0x01..0x7F) shortens the first second of each minute to SEC_COUNTS - 4*C enables. 0x01 removes 4 counts and 0x7F removes 508 counts.
- R4: A negative active calibration shown as two's complement lengthens the first second by 4*|C|. 0xFF adds 4 counts and 0x80 adds 512 counts.
- R5: Seconds 1 through SECS_PER_MIN-1 of every minute last exactly SEC_COUNTS enables, whatever the calibration.
- R6: A new calibration value is sampled only at a minute boundary. A write made during a minute leaves the remaining seconds of that minute unchanged.
- R7: `min_tick` pulses together with `sec_tick` on every SECS_PER_MIN-th second tick (default 60), and at no other time.
- R8: `sec_tick` is high for exactly one cycle per second. `sec_clk` is high for the first floor(L/2) counts of a second of length L and low for the rest.
- R9: With select 2'b00 and the enable set, the pin follows the alarm pulse input one cycle later.
- R10: With select 2'b01 and the enable set, the pin follows `sec_clk` one cycle later.
- R11: With select 2'b10 and the enable set, the pin follows the source enable one cycle later.
- R12: Select 2'b11 is reserved and holds the pin low.
- R13: While the output enable is clear, the pin is low for every select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 1 | One-cycle strobe per source clock period |
| alarm_pulse | input | 1 | Alarm pulse from the comparison logic |
| cfg_we | input | 1 | Loads the three configuration fields below |
| cfg_cal | input | 8 | Signed drift calibration value |
| cfg_sel | input | 2 | Pin source select code |
| cfg_oe | input | 1 | Pin output enable |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| sec_clk | output | 1 | Seconds square wave |
| rtc_pin | output | 1 | Gated, selected output pin |

## Verification
The divider is first run with an unbroken source enable and a zero calibration, which establishes the nominal second and the square-wave duty. Directed calibration values at both ends of the positive and negative ranges are then written part way through a minute. This separates "applied at the boundary" from "applied at once" and "applied to every second". Randomised phases thin the source enable at random and pick random calibration values, select codes, enables and alarm pulses. These phases show that lengths are counted in source enables and not in system cycles, and that each select code routes its own signal. Short directed runs on the reserved code and with the enable cleared close the pin cases.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef enum logic [1:0] {
    PIN_ALARM  = 2'b00,
    PIN_SECCLK = 2'b01,
    PIN_SOURCE = 2'b10,
    PIN_RSVD   = 2'b11
  } pin_sel_e;

  // Width that holds a count up to and including max_val.
  function automatic int cnt_width(input int max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int SEC_COUNTS = 32768,
  parameter int STEP       = 4,
  parameter int CAL_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_en,
  input  logic             first_sec,
  input  logic [CAL_W-1:0] cal_act,
  output logic             sec_wrap,
  output logic             sec_tick,
  output logic             sec_clk
);
  import rtc_trim_pkg::*;

  localparam int MAX_LEN = SEC_COUNTS + STEP * (2 ** (CAL_W - 1));
  localparam int CNT_W   = cnt_width(MAX_LEN);
  localparam int LW      = CNT_W + 2;
  localparam logic signed [LW-1:0] BASE_S = LW'(SEC_COUNTS);
  localparam logic signed [LW-1:0] STEP_S = LW'(STEP);

  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        cur_len;
  logic signed [LW-1:0]    cal_ext;
  logic signed [LW-1:0]    len_s;

  // Length of the running second: trimmed only in the first second.
  always_comb begin
    cal_ext = {{(LW-CAL_W){cal_act[CAL_W-1]}}, cal_act};
    if (first_sec) len_s = BASE_S - cal_ext * STEP_S;
    else           len_s = BASE_S;
    cur_len = len_s[CNT_W-1:0];
  end

  assign sec_wrap = src_en && (cnt == cur_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sec_tick <= 1'b0;
      sec_clk  <= 1'b0;
    end else begin
      sec_tick <= sec_wrap;
      sec_clk  <= (cnt < (cur_len >> 1));
      if (src_en) begin
        if (sec_wrap) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_len); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick); // R8

  AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !src_en |=> $stable(cnt)); // R2

endmodule

// File: rtl/rtc_min_sequencer.sv
module rtc_min_sequencer #(
  parameter int SECS_PER_MIN = 60,
  parameter int CAL_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_wrap,
  input  logic [CAL_W-1:0] cal_reg,
  output logic             first_sec,
  output logic [CAL_W-1:0] cal_act,
  output logic             min_tick
);
  import rtc_trim_pkg::*;

  localparam int IDX_W = cnt_width(SECS_PER_MIN - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECS_PER_MIN - 1);

  logic [IDX_W-1:0] sec_idx;
  logic             min_wrap;

  assign first_sec = (sec_idx == '0);
  assign min_wrap  = sec_wrap && (sec_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx  <= '0;
      cal_act  <= '0;
      min_tick <= 1'b0;
    end else begin
      min_tick <= min_wrap;
      if (min_wrap) begin
        sec_idx <= '0;
        cal_act <= cal_reg;
      end else if (sec_wrap) begin
        sec_idx <= sec_idx + IDX_W'(1);
      end
    end
  end

  AST_CAL_HELD_IN_MINUTE: assert property (@(posedge clk) disable iff (rst)
    !min_wrap |=> $stable(cal_act)); // R6

  AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    sec_idx <= LAST_IDX); // R7

endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux (
  input  logic       clk,
  input  logic       rst,
  input  logic       oe,
  input  logic [1:0] sel,
  input  logic       alarm,
  input  logic       sec_clk,
  input  logic       src_en,
  output logic       pin
);
  import rtc_trim_pkg::*;

  logic pin_d;

  always_comb begin
    pin_d = 1'b0;
    if (oe) begin
      unique case (pin_sel_e'(sel))
        PIN_ALARM:  pin_d = alarm;
        PIN_SECCLK: pin_d = sec_clk;
        PIN_SOURCE: pin_d = src_en;
        PIN_RSVD:   pin_d = 1'b0;
        default:    pin_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= pin_d;
  end

  AST_PIN_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !pin); // R13

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |=> !pin); // R12

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
  parameter int SEC_COUNTS   = 32768,
  parameter int SECS_PER_MIN = 60,
  parameter int STEP         = 4,
  parameter int CAL_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_en,
  input  logic             alarm_pulse,
  input  logic             cfg_we,
  input  logic [CAL_W-1:0] cfg_cal,
  input  logic [1:0]       cfg_sel,
  input  logic             cfg_oe,
  output logic             sec_tick,
  output logic             min_tick,
  output logic             sec_clk,
  output logic             rtc_pin
);

  logic [CAL_W-1:0] cal_reg;
  logic [1:0]       sel_reg;
  logic             oe_reg;
  logic             sec_wrap;
  logic             first_sec;
  logic [CAL_W-1:0] cal_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_reg <= '0;
      sel_reg <= '0;
      oe_reg  <= 1'b0;
    end else if (cfg_we) begin
      cal_reg <= cfg_cal;
      sel_reg <= cfg_sel;
      oe_reg  <= cfg_oe;
    end
  end

  rtc_sec_divider #(
    .SEC_COUNTS (SEC_COUNTS),
    .STEP       (STEP),
    .CAL_W      (CAL_W)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .src_en    (src_en),
    .first_sec (first_sec),
    .cal_act   (cal_act),
    .sec_wrap  (sec_wrap),
    .sec_tick  (sec_tick),
    .sec_clk   (sec_clk)
  );

  rtc_min_sequencer #(
    .SECS_PER_MIN (SECS_PER_MIN),
    .CAL_W        (CAL_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sec_wrap  (sec_wrap),
    .cal_reg   (cal_reg),
    .first_sec (first_sec),
    .cal_act   (cal_act),
    .min_tick  (min_tick)
  );

  rtc_pin_mux u_pin (
    .clk     (clk),
    .rst     (rst),
    .oe      (oe_reg),
    .sel     (sel_reg),
    .alarm   (alarm_pulse),
    .sec_clk (sec_clk),
    .src_en  (src_en),
    .pin     (rtc_pin)
  );

  AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (rst)
    min_tick |-> sec_tick); // R7

  AST_CFG_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (cal_reg == '0 && sel_reg == '0 && !oe_reg)); // R1

endmodule

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb_top;
  localparam int N  = 1024;
  localparam int S  = 4;
  localparam int ST = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_en = 1'b0;
  logic       alarm = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_cal = '0;
  logic [1:0] cfg_sel = '0;
  logic       cfg_oe = 1'b0;
  logic       sec_tick, min_tick, sec_clk, rtc_pin;

  always #10 clk = ~clk;

  rtc_trim_prescaler #(.SEC_COUNTS(N), .SECS_PER_MIN(S), .STEP(ST), .CAL_W(8)) dut_i (
    .clk(clk), .rst(rst), .src_en(src_en), .alarm_pulse(alarm),
    .cfg_we(cfg_we), .cfg_cal(cfg_cal), .cfg_sel(cfg_sel), .cfg_oe(cfg_oe),
    .sec_tick(sec_tick), .min_tick(min_tick), .sec_clk(sec_clk), .rtc_pin(rtc_pin)
  );

  int  vectors = 0, errors = 0;
  int  used_cnt = 0, last_tick_cnt = 0, idx = 0, act_cal = 0, high_cnt = 0, mins = 0;
  int  sh_cal = 0, p_cal = 0;
  bit  [1:0] sh_sel = 0, p_sel = 0;
  bit  sh_oe = 0, p_oe = 0, pend = 0;
  bit  prev_en = 0, prev_alarm = 0, prev_secclk = 0, prev_tick = 0;
  bit  cont = 0, r6_flag = 0, done = 0;
  int  cycles = 0;

  function automatic int sx8(input bit [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pin_model();
    if (!sh_oe) return 1'b0;
    case (sh_sel)
      2'b00:   return prev_alarm;
      2'b01:   return prev_secclk;
      2'b10:   return prev_en;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string pin_tag();
    if (!sh_oe) return "R13 pin gated";
    case (sh_sel)
      2'b00:   return "R9 alarm on pin";
      2'b01:   return "R10 sec_clk on pin";
      2'b10:   return "R11 source on pin";
      default: return "R12 reserved code";
    endcase
  endfunction

  task automatic step(input bit en, input bit alm, input bit we,
                      input bit [7:0] c, input bit [1:0] s, input bit o);
    int len_exp;
    string tag;
    @(negedge clk);
    check(rtc_pin == pin_model(), pin_tag(), rtc_pin, pin_model());
    if (sec_tick) begin
      check(!prev_tick, "R8 tick width", 2, 1);
      check(min_tick == (idx == S - 1), "R7 minute tick", min_tick, (idx == S - 1));
      len_exp = (idx == 0) ? N - ST * act_cal : N;
      if (idx != 0 && r6_flag) begin tag = "R6 late write held"; r6_flag = 0; end
      else if (idx != 0)       tag = "R5 untrimmed second";
      else if (act_cal > 0)    tag = "R3 shortened second";
      else if (act_cal < 0)    tag = "R4 lengthened second";
      else                     tag = "R2 nominal second";
      check(used_cnt - last_tick_cnt == len_exp, tag, used_cnt - last_tick_cnt, len_exp);
      if (cont) check(high_cnt == len_exp / 2, "R8 sec_clk duty", high_cnt, len_exp / 2);
      last_tick_cnt = used_cnt;
      high_cnt = 0;
      cont = 1;
      if (min_tick) begin act_cal = sh_cal; idx = 0; mins++; end
      else idx++;
    end else begin
      check(!min_tick, "R7 no stray minute tick", min_tick, 0);
    end
    if (sec_clk) high_cnt++;
    prev_tick = sec_tick;
    prev_secclk = sec_clk;
    if (pend) begin
      sh_cal = p_cal; sh_sel = p_sel; sh_oe = p_oe;
      if (idx != 0) r6_flag = 1;
    end
    pend = we; p_cal = sx8(c); p_sel = s; p_oe = o;
    src_en = en; alarm = alm; cfg_we = we; cfg_cal = c; cfg_sel = s; cfg_oe = o;
    if (en) used_cnt++;
    if (!en) cont = 0;
    prev_en = en; prev_alarm = alm;
  endtask

  task automatic idle_run(input bit en, input int n);
    for (int i = 0; i < n; i++) step(en, 1'b0, 1'b0, 8'h00, sh_sel, sh_oe);
  endtask

  task automatic trim_case(input bit [7:0] c, input bit [1:0] s, input bit o);
    int m0;
    while (idx != 1) step(1'b1, 1'b0, 1'b0, 8'h00, sh_sel, sh_oe);
    step(1'b1, 1'b0, 1'b1, c, s, o);
    m0 = mins;
    while (mins < m0 + 2) step(1'b1, 1'b0, 1'b0, 8'h00, sh_sel, sh_oe);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R1: reset state
    check(sec_tick == 0, "R1 reset tick", sec_tick, 0);
    check(min_tick == 0, "R1 reset min", min_tick, 0);
    check(rtc_pin == 0, "R1 reset pin", rtc_pin, 0);
    check(sec_clk == 0, "R1 reset sec_clk", sec_clk, 0);
    rst = 1'b0;
    // R1: first second nominal with no write, pin stays low
    idle_run(1'b1, 1500);
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'b01, 1'b1);
    idle_run(1'b1, 8000);
    // Directed trims, each written mid-minute
    trim_case(8'h01, 2'b01, 1'b1);
    trim_case(8'h7F, 2'b01, 1'b1);
    trim_case(8'hFF, 2'b01, 1'b1);
    trim_case(8'h80, 2'b01, 1'b1);
    trim_case(8'h00, 2'b01, 1'b1);
    // Random phases
    for (int k = 0; k < 4; k++) begin
      int m0;
      bit [7:0] rc;
      rc = 8'($urandom);
      while (idx != 2) step($urandom_range(3, 0) != 0, 1'b0, 1'b0, 8'h00, sh_sel, sh_oe);
      step(1'b1, 1'b0, 1'b1, rc, 2'($urandom), 1'($urandom));
      m0 = mins;
      while (mins < m0 + 1) begin
        bit we;
        we = ($urandom_range(200, 0) == 0) && (idx != 0) && (idx != S - 1);
        step($urandom_range(3, 0) != 0, 1'($urandom), we, rc, 2'($urandom), 1'($urandom));
      end
    end
    // Directed pin cases
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'b11, 1'b1);
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'($urandom), 1'b0, 8'h00, 2'b11, 1'b1);
    check(rtc_pin == 0, "R12 reserved pin", rtc_pin, 0);
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b1, 1'b1, 8'h00, 2'(s), 1'b0);
      for (int i = 0; i < 40; i++) step(1'($urandom), 1'($urandom), 1'b0, 8'h00, 2'(s), 1'b0);
    end
    check(rtc_pin == 0, "R13 gated pin", rtc_pin, 0);
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'b00, 1'b1);
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'($urandom), 1'b0, 8'h00, 2'b00, 1'b1);
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'b10, 1'b1);
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'($urandom), 1'b0, 8'h00, 2'b10, 1'b1);
    idle_run(1'b0, 4);
    finish_run();
  end

endmodule